// File: doc/BRIEF.md
# Sector Protection Command Recognizer

This block sits behind a serial-flash front end that has already turned chip select and serial data into a synchronous frame flag and a stream of received bytes. It watches every frame for the four-byte command sequences that govern sector write protection. It holds the software protection enable and a 16-byte protection map, one byte per sector. It answers status and map reads by setting the byte the front end shifts out in the next byte slot.

The program/erase controller drives a page number into the block. Protection is active when the software enable is set or the hardware write-protect input is high. The block then reports whether the sector holding that page is flagged in the map. Sector 0 is split: its first 8 pages and its remaining 504 pages are governed by different bit pairs of the sector 0 map byte.

Map erase and map load are modelled as a fixed busy period. The map changes when that period ends.

Top module: `sect_guard`

## Requirements
- R1: After reset, `tx_byte` is 00h, `busy` is 0, `prot_enabled` is 0, every map byte is 00h, and `page_prot` is 0.
- R2: The frame 3Dh 2Ah 7Fh A9h sets the software enable. It takes effect only once `frame_active` falls after the fourth byte; while the frame is still held, `prot_enabled` stays unchanged.
- R3: The frame 3Dh 2Ah 7Fh 9Ah clears the software enable at frame end. It is ignored if `wp` is high in the cycle the frame ends.
- R4: A frame with any wrong byte, a frame released before its fourth byte, or a four-byte command frame followed by any extra byte changes no state.
- R5: The frame 3Dh 2Ah 7Fh CFh, at frame end, raises `busy` for exactly BUSY_CYCLES cycles. When `busy` falls, every map byte becomes FFh.
- R6: The frame 3Dh 2Ah 7Fh FCh followed by 16 bytes raises `busy` for BUSY_CYCLES cycles. Afterwards map byte k holds the k-th following byte (k = 0..15). A load frame with fewer than 16 data bytes is discarded and raises no busy.
- R7: The frame 32h 00h 00h 00h followed by four dummy bytes makes `tx_byte` present map byte 0 after the fourth dummy. Each further byte advances to the next sector, wrapping from sector 15 to sector 0.
- R8: After opcode D7h, and after every later byte in that frame, `tx_byte` is the status byte {ready, cmp_mismatch, 1, 1, 0, 1, protect, 0}, bit 7 first. The ready bit is 1 when neither `busy` nor `ext_busy` is high. The protect bit is 1 when protection is active.
- R9: Protection is active, as shown on `prot_enabled` one cycle later, when the software enable is set or `wp` is high.
- R10: `page_prot` is 1, one cycle after the page address, only if protection is active and the page's sector is flagged. Sectors 1..15 are flagged by map byte FFh. For sector 0, pages 0..7 are flagged by bits 7:6 both 1, and pages 8..511 by bits 5:4 both 1.
- R11: While `busy` or `ext_busy` is high, any frame whose first byte is not D7h is ignored. `busy` rises only after `frame_active` has fallen.
- R12: The status ready bit is 0 whenever `ext_busy` is high, even when the block itself is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_active | input | 1 | High while chip select is asserted |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte, already assembled MSB first |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| wp | input | 1 | Hardware write-protect, active high |
| ext_busy | input | 1 | Busy from the array program/erase controller |
| cmp_mismatch | input | 1 | Result of the most recent page compare (1 = differs) |
| page_addr | input | 13 | Page the program/erase controller intends to alter |
| page_prot | output | 1 | Registered: that page is write protected |
| prot_enabled | output | 1 | Registered: protection is active |
| busy | output | 1 | Map erase or map load in progress |

## Verification
The checker assumes that `rx_valid` pulses only while `frame_active` is high. It also assumes that frames are separated by at least one cycle with `frame_active` low, so every frame end is seen as a falling edge. The stimulus tasks raise `frame_active` a cycle before the first byte, space bytes two cycles apart, and hold it low for several cycles between frames. The busy-length and busy-start properties rely on the front end never starting a new frame in the same cycle the previous one ends, and the bench keeps to that throughout.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;
  localparam logic [7:0] KEY_B0   = 8'h3D;
  localparam logic [7:0] KEY_B1   = 8'h2A;
  localparam logic [7:0] KEY_B2   = 8'h7F;
  localparam logic [7:0] SUF_ON   = 8'hA9;
  localparam logic [7:0] SUF_OFF  = 8'h9A;
  localparam logic [7:0] SUF_WIPE = 8'hCF;
  localparam logic [7:0] SUF_LOAD = 8'hFC;
  localparam logic [7:0] OP_STAT  = 8'hD7;
  localparam logic [7:0] OP_MAPRD = 8'h32;
  localparam logic [3:0] DENSITY  = 4'b1101;

  typedef enum logic [3:0] {
    CMD_IDLE,
    CMD_PFX,
    CMD_RDH,
    CMD_STAT,
    CMD_RDMAP,
    CMD_ON,
    CMD_OFF,
    CMD_WIPE,
    CMD_LOAD,
    CMD_VOID
  } cmd_e;
endpackage

// File: rtl/sg_cmd_parse.sv
module sg_cmd_parse
  import sect_guard_pkg::*;
#(
  parameter int SECT_W = 4,
  parameter int IDX_W  = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             frame_active,
  input  logic                             rx_valid,
  input  logic [7:0]                       rx_byte,
  input  logic                             busy_any,
  input  logic [7:0]                       status_byte,
  input  logic [(1<<SECT_W)-1:0][7:0]      map,
  output logic [7:0]                       tx_byte,
  output logic                             stg_we,
  output logic [SECT_W-1:0]                stg_addr,
  output logic [7:0]                       stg_data,
  output logic                             ev_on,
  output logic                             ev_off,
  output logic                             ev_wipe,
  output logic                             ev_load
);
  localparam int NSECT = 1 << SECT_W;
  localparam int LC_W  = SECT_W + 1;
  localparam logic [IDX_W-1:0] RD_LEAD = IDX_W'(7);

  cmd_e              kind, kind_n;
  logic [IDX_W-1:0]  idx;
  logic [SECT_W-1:0] rd_ptr;
  logic [LC_W-1:0]   load_cnt;
  logic              frame_q;
  logic              frame_end;
  logic              load_room;

  assign frame_end = frame_q & ~frame_active;
  assign load_room = load_cnt < LC_W'(NSECT);

  always_comb begin
    kind_n = kind;
    unique case (kind)
      CMD_IDLE: begin
        if (rx_byte == OP_STAT)       kind_n = CMD_STAT;
        else if (busy_any)            kind_n = CMD_VOID;
        else if (rx_byte == KEY_B0)   kind_n = CMD_PFX;
        else if (rx_byte == OP_MAPRD) kind_n = CMD_RDH;
        else                          kind_n = CMD_VOID;
      end
      CMD_PFX: begin
        if (idx == IDX_W'(1)) begin
          if (rx_byte != KEY_B1) kind_n = CMD_VOID;
        end else if (idx == IDX_W'(2)) begin
          if (rx_byte != KEY_B2) kind_n = CMD_VOID;
        end else begin
          unique case (rx_byte)
            SUF_ON:   kind_n = CMD_ON;
            SUF_OFF:  kind_n = CMD_OFF;
            SUF_WIPE: kind_n = CMD_WIPE;
            SUF_LOAD: kind_n = CMD_LOAD;
            default:  kind_n = CMD_VOID;
          endcase
        end
      end
      CMD_RDH: begin
        if (rx_byte != 8'h00)         kind_n = CMD_VOID;
        else if (idx == IDX_W'(3))    kind_n = CMD_RDMAP;
      end
      CMD_ON, CMD_OFF, CMD_WIPE:      kind_n = CMD_VOID;
      default:                        kind_n = kind;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b0;
    else     frame_q <= frame_active;
  end

  always_ff @(posedge clk) begin
    if (rst || !frame_active) begin
      kind     <= CMD_IDLE;
      idx      <= '0;
      rd_ptr   <= '0;
      load_cnt <= '0;
      tx_byte  <= 8'h00;
    end else if (rx_valid) begin
      kind <= kind_n;
      if (idx != {IDX_W{1'b1}}) idx <= idx + 1'b1;
      if (kind_n == CMD_STAT) begin
        tx_byte <= status_byte;
      end else if (kind_n == CMD_RDMAP && idx >= RD_LEAD) begin
        tx_byte <= map[rd_ptr];
        rd_ptr  <= rd_ptr + 1'b1;
      end else begin
        tx_byte <= 8'h00;
      end
      if (kind == CMD_LOAD && load_room) load_cnt <= load_cnt + 1'b1;
    end
  end

  assign stg_we   = frame_active & rx_valid & (kind == CMD_LOAD) & load_room;
  assign stg_addr = load_cnt[SECT_W-1:0];
  assign stg_data = rx_byte;

  assign ev_on   = frame_end & (kind == CMD_ON);
  assign ev_off  = frame_end & (kind == CMD_OFF);
  assign ev_wipe = frame_end & (kind == CMD_WIPE);
  assign ev_load = frame_end & (kind == CMD_LOAD) & (load_cnt == LC_W'(NSECT));
endmodule

// File: rtl/sg_map_store.sv
module sg_map_store #(
  parameter int SECT_W      = 4,
  parameter int BUSY_CYCLES = 40
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wp,
  input  logic                        ev_on,
  input  logic                        ev_off,
  input  logic                        ev_wipe,
  input  logic                        ev_load,
  input  logic                        stg_we,
  input  logic [SECT_W-1:0]           stg_addr,
  input  logic [7:0]                  stg_data,
  output logic [(1<<SECT_W)-1:0][7:0] map,
  output logic                        sw_en,
  output logic                        busy
);
  localparam int NSECT = 1 << SECT_W;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [NSECT-1:0][7:0] stage;
  logic [CNT_W-1:0]      cnt;
  logic                  op_load;

  always_ff @(posedge clk) begin
    if (stg_we) stage[stg_addr] <= stg_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en   <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      op_load <= 1'b0;
      map     <= '0;
    end else begin
      if (ev_on)         sw_en <= 1'b1;
      if (ev_off && !wp) sw_en <= 1'b0;
      if (!busy && (ev_wipe || ev_load)) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(BUSY_CYCLES - 1);
        op_load <= ev_load;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          map  <= op_load ? stage : '1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sg_page_lookup.sv
module sg_page_lookup #(
  parameter int PAGE_W    = 13,
  parameter int SECT_W    = 4,
  parameter int SUB_PAGES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PAGE_W-1:0]           page_addr,
  input  logic [(1<<SECT_W)-1:0][7:0] map,
  input  logic                        prot_on,
  output logic                        page_prot
);
  localparam int OFF_W = PAGE_W - SECT_W;

  logic [SECT_W-1:0] sector;
  logic [7:0]        sel_map;
  logic              low_part;
  logic              hit;

  assign sector   = page_addr[PAGE_W-1 -: SECT_W];
  assign sel_map  = map[sector];
  assign low_part = page_addr[OFF_W-1:0] < OFF_W'(SUB_PAGES);

  always_comb begin
    if (sector == '0) hit = low_part ? (&sel_map[7:6]) : (&sel_map[5:4]);
    else              hit = &sel_map;
  end

  always_ff @(posedge clk) begin
    if (rst) page_prot <= 1'b0;
    else     page_prot <= prot_on & hit;
  end
endmodule

// File: rtl/sect_guard.sv
module sect_guard
  import sect_guard_pkg::*;
#(
  parameter int PAGE_W      = 13,
  parameter int SECT_W      = 4,
  parameter int SUB_PAGES   = 8,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_active,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        tx_byte,
  input  logic              wp,
  input  logic              ext_busy,
  input  logic              cmp_mismatch,
  input  logic [PAGE_W-1:0] page_addr,
  output logic              page_prot,
  output logic              prot_enabled,
  output logic              busy
);
  localparam int NSECT = 1 << SECT_W;

  logic [NSECT-1:0][7:0] map;
  logic                  sw_en, prot_on;
  logic                  stg_we;
  logic [SECT_W-1:0]     stg_addr;
  logic [7:0]            stg_data;
  logic                  ev_on, ev_off, ev_wipe, ev_load;
  logic [7:0]            status_byte;

  assign prot_on     = sw_en | wp;
  assign status_byte = {~(busy | ext_busy), cmp_mismatch, DENSITY, prot_on, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) prot_enabled <= 1'b0;
    else     prot_enabled <= prot_on;
  end

  sg_cmd_parse #(.SECT_W(SECT_W)) u_parse (
    .clk(clk), .rst(rst), .frame_active(frame_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .busy_any(busy | ext_busy), .status_byte(status_byte),
    .map(map), .tx_byte(tx_byte), .stg_we(stg_we), .stg_addr(stg_addr),
    .stg_data(stg_data), .ev_on(ev_on), .ev_off(ev_off), .ev_wipe(ev_wipe),
    .ev_load(ev_load)
  );

  sg_map_store #(.SECT_W(SECT_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst(rst), .wp(wp), .ev_on(ev_on), .ev_off(ev_off),
    .ev_wipe(ev_wipe), .ev_load(ev_load), .stg_we(stg_we), .stg_addr(stg_addr),
    .stg_data(stg_data), .map(map), .sw_en(sw_en), .busy(busy)
  );

  sg_page_lookup #(.PAGE_W(PAGE_W), .SECT_W(SECT_W), .SUB_PAGES(SUB_PAGES)) u_lookup (
    .clk(clk), .rst(rst), .page_addr(page_addr), .map(map), .prot_on(prot_on),
    .page_prot(page_prot)
  );
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int BUSY_CYCLES = 40
) (
  input logic clk,
  input logic rst,
  input logic wp,
  input logic busy,
  input logic frame_active,
  input logic page_prot,
  input logic prot_enabled
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R10
  page_lock_chk: assert property (@(posedge clk) disable iff (rst)
    page_prot |-> prot_enabled);

  // R9
  hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
    wp |=> prot_enabled);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == RUN_W'(BUSY_CYCLES)));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(frame_active));
endmodule

bind sect_guard sg_guard_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_guard_chk (
  .clk(clk), .rst(rst), .wp(wp), .busy(busy), .frame_active(frame_active),
  .page_prot(page_prot), .prot_enabled(prot_enabled)
);

// File: tb/tb_sect_guard.sv
module tb_sect_guard;
  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_active = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [7:0]  tx_byte;
  logic        wp = 1'b0;
  logic        ext_busy = 1'b0;
  logic        cmp_mismatch = 1'b0;
  logic [12:0] page_addr = '0;
  logic        page_prot, prot_enabled, busy;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_map [16];

  always #2.5 clk = ~clk;

  sect_guard #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst(rst), .frame_active(frame_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .wp(wp), .ext_busy(ext_busy),
    .cmp_mismatch(cmp_mismatch), .page_addr(page_addr), .page_prot(page_prot),
    .prot_enabled(prot_enabled), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic rdy, input logic cmp, input logic prot);
    return {rdy, cmp, 4'b1101, prot, 1'b0};
  endfunction

  task automatic begin_frame();
    @(negedge clk) frame_active = 1'b1;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge clk) frame_active = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame4(input logic [7:0] a, b, c, d);
    begin_frame(); put(a); put(b); put(c); put(d); end_frame();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < BUSY + 20 && busy; i++) @(negedge clk);
  endtask

  task automatic page_chk(input string req, input int p, input logic exp);
    @(negedge clk) page_addr = 13'(p);
    @(negedge clk);
    @(negedge clk);
    chk(req, {7'd0, page_prot}, {7'd0, exp});
  endtask

  task automatic read_map_chk(input string req);
    begin_frame();
    put(8'h32); put(8'h00); put(8'h00); put(8'h00);
    for (int i = 0; i < 4; i++) put(8'h00);
    chk(req, tx_byte, exp_map[0]);
    for (int k = 1; k <= 16; k++) begin
      put(8'hFF);
      chk(req, tx_byte, exp_map[k % 16]);
    end
    end_frame();
  endtask

  task automatic t_reset();
    chk("R1 tx", tx_byte, 8'h00);
    chk("R1 busy", {7'd0, busy}, 8'h00);
    chk("R1 prot", {7'd0, prot_enabled}, 8'h00);
    for (int i = 0; i < 16; i++) exp_map[i] = 8'h00;
    read_map_chk("R1 map");
  endtask

  task automatic t_bad();
    begin_frame(); put(8'h3D); put(8'h2A); put(8'h7F); end_frame();
    chk("R4 early release", {7'd0, prot_enabled}, 8'h00);
    frame4(8'h3D, 8'h2A, 8'h7E, 8'hA9);
    chk("R4 wrong byte", {7'd0, prot_enabled}, 8'h00);
    begin_frame(); put(8'h3D); put(8'h2A); put(8'h7F); put(8'hA9); put(8'h00); end_frame();
    chk("R4 extra byte", {7'd0, prot_enabled}, 8'h00);
    begin_frame(); put(8'h3D); put(8'h2A); put(8'h7F); put(8'hCF); put(8'h11); end_frame();
    chk("R4 extra byte no busy", {7'd0, busy}, 8'h00);
  endtask

  task automatic t_enable();
    begin_frame(); put(8'h3D); put(8'h2A); put(8'h7F); put(8'hA9);
    repeat (4) @(negedge clk);
    chk("R2 held frame", {7'd0, prot_enabled}, 8'h00);
    end_frame();
    chk("R2 enable", {7'd0, prot_enabled}, 8'h01);
    page_chk("R10 map clear", 5, 1'b0);
  endtask

  task automatic t_wipe();
    frame4(8'h3D, 8'h2A, 8'h7F, 8'hCF);
    chk("R5 busy", {7'd0, busy}, 8'h01);
    begin_frame(); put(8'hD7);
    chk("R8 ready low while busy", tx_byte, stat(1'b0, 1'b0, 1'b1));
    end_frame();
    frame4(8'h3D, 8'h2A, 8'h7F, 8'h9A);
    wait_idle();
    chk("R5 busy ends", {7'd0, busy}, 8'h00);
    chk("R11 disable ignored while busy", {7'd0, prot_enabled}, 8'h01);
    for (int i = 0; i < 16; i++) exp_map[i] = 8'hFF;
    read_map_chk("R5 map erased");
    page_chk("R10 erased low", 3, 1'b1);
    page_chk("R10 erased high", 100, 1'b1);
  endtask

  task automatic t_load();
    logic [7:0] nm [16];
    nm[0] = 8'hC0; nm[1] = 8'hFF; nm[2] = 8'h00; nm[15] = 8'hFF;
    for (int i = 3; i < 15; i++) nm[i] = 8'h5A;
    begin_frame(); put(8'h3D); put(8'h2A); put(8'h7F); put(8'hFC);
    for (int i = 0; i < 15; i++) put(nm[i]);
    end_frame();
    chk("R6 short load no busy", {7'd0, busy}, 8'h00);
    read_map_chk("R6 short load discarded");
    begin_frame(); put(8'h3D); put(8'h2A); put(8'h7F); put(8'hFC);
    for (int i = 0; i < 16; i++) put(nm[i]);
    put(8'h00);
    end_frame();
    chk("R6 load busy", {7'd0, busy}, 8'h01);
    wait_idle();
    for (int i = 0; i < 16; i++) exp_map[i] = nm[i];
    read_map_chk("R6 R7 loaded map");
    page_chk("R10 s0 low C0", 5, 1'b1);
    page_chk("R10 s0 high C0", 8, 1'b0);
    page_chk("R10 s1 FF", 515, 1'b1);
    page_chk("R10 s2 00", 1024, 1'b0);
    page_chk("R10 s3 5A", 1536, 1'b0);
    page_chk("R10 s15 FF", 8191, 1'b1);
  endtask

  task automatic t_disable();
    @(negedge clk) wp = 1'b1;
    frame4(8'h3D, 8'h2A, 8'h7F, 8'h9A);
    @(negedge clk) wp = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 disable ignored with wp", {7'd0, prot_enabled}, 8'h01);
    frame4(8'h3D, 8'h2A, 8'h7F, 8'h9A);
    chk("R3 disable", {7'd0, prot_enabled}, 8'h00);
    page_chk("R10 inactive", 5, 1'b0);
  endtask

  task automatic t_hw();
    @(negedge clk) wp = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 wp enables", {7'd0, prot_enabled}, 8'h01);
    page_chk("R9 wp page", 5, 1'b1);
    begin_frame(); put(8'hD7);
    chk("R9 status protect bit", tx_byte, stat(1'b1, 1'b0, 1'b1));
    end_frame();
    @(negedge clk) wp = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 wp released", {7'd0, prot_enabled}, 8'h00);
  endtask

  task automatic t_status();
    @(negedge clk) cmp_mismatch = 1'b1;
    begin_frame(); put(8'hD7);
    chk("R8 status", tx_byte, stat(1'b1, 1'b1, 1'b0));
    put(8'h00);
    chk("R8 repeat", tx_byte, stat(1'b1, 1'b1, 1'b0));
    @(negedge clk) ext_busy = 1'b1;
    put(8'h00);
    chk("R12 ext busy", tx_byte, stat(1'b0, 1'b1, 1'b0));
    end_frame();
    frame4(8'h3D, 8'h2A, 8'h7F, 8'hA9);
    chk("R11 enable ignored with ext busy", {7'd0, prot_enabled}, 8'h00);
    @(negedge clk) begin ext_busy = 1'b0; cmp_mismatch = 1'b0; end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bad();
    t_enable();
    t_wipe();
    t_load();
    t_disable();
    t_hw();
    t_status();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule